// File: doc/BRIEF.md
# Single-Cycle ALU Instruction Core

This block is the execute slice of a single-cycle processor. It handles only arithmetic, logic, shift and compare instructions. In every clock cycle it drives the program counter out as the instruction address. It then takes the 32-bit instruction word that comes back combinationally and uses fixed bit positions to find the two source registers and the destination register. The opcode selects a row of a 64-entry control table, which gives the ALU function, the second-operand select and the register-write enable.

The second operand is either a register value or a 16-bit literal that is sign-extended. The ALU result is written to the destination register at the next rising clock edge, and the PC moves on by 4 at the same edge. The write-back triple (valid, destination, value) is also driven out of the block while the instruction is current, so that a surrounding core or a bench can watch results retire. An asynchronous active-low reset holds the PC at its start address and blocks all register writes. The reset must be released in step with the clock.

Top module: `scalu_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0x00000000, no register is written and `wb_valid` is low.
- R2: After reset release, `imem_addr` increases by exactly 4 at every rising clock edge, whatever the instruction.
- R3: The instruction fields are at fixed positions: opcode in bits [31:26], destination in [25:21], source A in [20:16], source B in [15:11], literal in [15:0].
- R4: Opcode bits [5:4] = 2'b10 selects the register-register form and 2'b11 selects the literal form. Bits [3:0] select the operation: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 shift-left, 6 logical shift-right, 7 arithmetic shift-right, 8 compare-equal, 9 signed less-than, 10 signed less-or-equal.
- R5: In the literal form, the second operand is bits [15:0] sign-extended from bit 15 to 32 bits.
- R6: ADD, SUB, AND, OR and XOR produce the 32-bit two's-complement result of A op B.
- R7: The shift operations shift A by the amount in the low 5 bits of the second operand. The arithmetic right shift replicates bit 31.
- R8: The compare operations evaluate signed A against B and give exactly 1 or 0.
- R9: Every opcode outside the two groups (including operation codes 11 to 15) writes nothing, and a later read of its destination register returns the old value.
- R10: Register 31 always reads as zero. A write aimed at it is dropped, and `wb_valid` stays low for it.
- R11: A value written at a clock edge is read by the very next instruction.
- R12: While an instruction is current, `wb_valid`, `wb_dst` and `wb_value` show the write it will perform at the coming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| imem_addr | output | 32 | Address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, supplied combinationally |
| wb_valid | output | 1 | High when the current instruction writes a register |
| wb_dst | output | 5 | Destination register index of the current instruction |
| wb_value | output | 32 | ALU result to be written at the next edge |

## Verification
The hardest property to reach from the ports is that an ignored write leaves no trace. Three cases need this: an unused opcode whose destination field names a live register, a write to register 31, and a write under reset. The first two can only be seen indirectly. The stimulus therefore uses a later instruction to copy the register that could have been touched into a visible write-back, and checks that it still holds its earlier value or zero. The program also sets up operand pairs that expose the harder cases: negative literals, shift amounts with upper bits set, signed comparisons across zero, and a register that is read in the cycle right after it was written.

// File: rtl/scalu_pkg.sv
package scalu_pkg;

  localparam int XLEN      = 32;
  localparam int OPC_W     = 6;
  localparam int FN_W      = 4;
  localparam int NUM_OPS   = 11;

  typedef enum logic [FN_W-1:0] {
    FN_ADD   = 4'd0,
    FN_SUB   = 4'd1,
    FN_AND   = 4'd2,
    FN_OR    = 4'd3,
    FN_XOR   = 4'd4,
    FN_SHL   = 4'd5,
    FN_SHR   = 4'd6,
    FN_SRA   = 4'd7,
    FN_CMPEQ = 4'd8,
    FN_CMPLT = 4'd9,
    FN_CMPLE = 4'd10,
    FN_NONE  = 4'd15
  } alufn_e;

  typedef struct packed {
    alufn_e fn;
    logic   use_lit;
    logic   reg_we;
  } ctrl_t;

  localparam logic [1:0] GRP_REGREG = 2'b10;
  localparam logic [1:0] GRP_LIT    = 2'b11;

endpackage

// File: rtl/scalu_ctrl_rom.sv
module scalu_ctrl_rom
  import scalu_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opcode,
  output ctrl_t         ctrl
);

  localparam int ENTRIES = 1 << OW;
  localparam int SEL_W   = OW - 2;

  function automatic ctrl_t row_for(input int unsigned idx);
    logic [OW-1:0]    code;
    logic [1:0]       grp;
    logic [SEL_W-1:0] sel;
    ctrl_t            r;
    code = OW'(idx);
    grp  = code[OW-1 -: 2];
    sel  = code[SEL_W-1:0];
    if (((grp == GRP_REGREG) || (grp == GRP_LIT)) && (int'(sel) < NUM_OPS)) begin
      r.fn      = alufn_e'(FN_W'(sel));
      r.use_lit = grp[0];
      r.reg_we  = 1'b1;
    end else begin
      r.fn      = FN_NONE;
      r.use_lit = 1'b0;
      r.reg_we  = 1'b0;
    end
    return r;
  endfunction

  ctrl_t table_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    assign table_q[e] = row_for(e);
  end

  assign ctrl = table_q[opcode];

  // R9: nothing with the top opcode bit clear may enable a write
  always_comb begin
    if (!opcode[OW-1]) begin
      p_low_half_nowrite_r9: assert (!ctrl.reg_we);
    end
  end

endmodule

// File: rtl/scalu_regfile.sv
module scalu_regfile #(
  parameter int W        = 32,
  parameter int NREGS    = 32,
  parameter int ZERO_IDX = NREGS - 1
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [W-1:0]             wd,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  output logic [W-1:0]             rd_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  output logic [W-1:0]             rd_b
);

  localparam int AW = $clog2(NREGS);

  logic [W-1:0] regs_q [NREGS];
  logic [NREGS-1:0] row_en;

  always_comb begin
    row_en = '0;
    if (we) row_en[wa] = 1'b1;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == ZERO_IDX) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (row_en[i]) regs_q[i] <= wd;
      end
    end
  end

  assign rd_a = (ra_a == AW'(ZERO_IDX)) ? '0 : regs_q[ra_a];
  assign rd_b = (ra_b == AW'(ZERO_IDX)) ? '0 : regs_q[ra_b];

endmodule

// File: rtl/scalu_alu.sv
module scalu_alu
  import scalu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alufn_e       fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] shamt;
  logic            lt_s;
  logic            eq;
  logic [W-1:0]    diff;

  assign shamt = b[SH_W-1:0];
  assign diff  = a - b;
  assign eq    = (a == b);
  assign lt_s  = $signed(a) < $signed(b);

  always_comb begin
    unique case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = diff;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_SHL:   y = a << shamt;
      FN_SHR:   y = a >> shamt;
      FN_SRA:   y = W'($signed(a) >>> shamt);
      FN_CMPEQ: y = W'(eq);
      FN_CMPLT: y = W'(lt_s);
      FN_CMPLE: y = W'(lt_s | eq);
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/scalu_core.sv
module scalu_core
  import scalu_pkg::*;
#(
  parameter int          W        = XLEN,
  parameter int          NREGS    = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          PC_STEP  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_data,
  output logic         wb_valid,
  output logic [4:0]   wb_dst,
  output logic [W-1:0] wb_value
);

  localparam int AW       = $clog2(NREGS);
  localparam int ZERO_IDX = NREGS - 1;
  localparam int OPC_LSB  = W - OPC_W;
  localparam int DST_LSB  = OPC_LSB - AW;
  localparam int SRCA_LSB = DST_LSB - AW;
  localparam int SRCB_LSB = SRCA_LSB - AW;
  localparam int LIT_W    = 16;

  // program counter: next-state and register processes
  logic [W-1:0] pc_q, pc_d;
  logic         pc_en;

  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q + W'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= W'(RESET_PC);
    else if (pc_en) pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  // field extraction
  logic [OPC_W-1:0] f_opc;
  logic [AW-1:0]    f_dst, f_srca, f_srcb;
  logic [LIT_W-1:0] f_lit;

  assign f_opc  = imem_data[W-1 -: OPC_W];
  assign f_dst  = imem_data[DST_LSB  +: AW];
  assign f_srca = imem_data[SRCA_LSB +: AW];
  assign f_srcb = imem_data[SRCB_LSB +: AW];
  assign f_lit  = imem_data[LIT_W-1:0];

  // decode
  ctrl_t ctl;

  scalu_ctrl_rom #(.OW(OPC_W)) u_ctrl (
    .opcode (f_opc),
    .ctrl   (ctl)
  );

  // register file
  logic [W-1:0] rf_a, rf_b;
  logic         rf_we;
  logic [W-1:0] alu_y;

  assign rf_we = ctl.reg_we & rst_n;

  scalu_regfile #(.W(W), .NREGS(NREGS), .ZERO_IDX(ZERO_IDX)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .wa   (f_dst),
    .wd   (alu_y),
    .ra_a (f_srca),
    .rd_a (rf_a),
    .ra_b (f_srcb),
    .rd_b (rf_b)
  );

  // operand B select
  logic [W-1:0] lit_ext, opnd_b;

  assign lit_ext = {{(W-LIT_W){f_lit[LIT_W-1]}}, f_lit};
  assign opnd_b  = ctl.use_lit ? lit_ext : rf_b;

  scalu_alu #(.W(W)) u_alu (
    .fn (ctl.fn),
    .a  (rf_a),
    .b  (opnd_b),
    .y  (alu_y)
  );

  // write-back observation
  assign wb_valid = rf_we & (f_dst != AW'(ZERO_IDX));
  assign wb_dst   = 5'(f_dst);
  assign wb_value = alu_y;

  // assertions
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> imem_addr == $past(imem_addr) + W'(PC_STEP));

  p_cmp_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fn inside {FN_CMPEQ, FN_CMPLT, FN_CMPLE}) |-> alu_y[W-1:1] == '0);

  p_zero_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (f_srca == AW'(ZERO_IDX)) |-> rf_a == '0);

  p_lit_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.use_lit && f_lit[LIT_W-1]) |-> opnd_b[W-1] == 1'b1);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_rst_nowrite_r1: assert (!rf_we);
      p_rst_pc_r1:      assert (pc_q == W'(RESET_PC));
    end
  end

endmodule

// File: tb/scalu_core_bench.sv
module scalu_core_bench;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] imem_addr;
  logic [W-1:0] imem_data;
  logic         wb_valid;
  logic [4:0]   wb_dst;
  logic [W-1:0] wb_value;

  scalu_core u_scalu_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .wb_valid  (wb_valid),
    .wb_dst    (wb_dst),
    .wb_value  (wb_value)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // operation codes (R4)
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_SHL = 4'd5, OP_SHR = 4'd6, OP_SRA = 4'd7,
                         OP_EQ  = 4'd8, OP_LT  = 4'd9, OP_LE  = 4'd10;

  function automatic logic [5:0] rr(input logic [3:0] op);
    return {2'b10, op};
  endfunction
  function automatic logic [5:0] lit(input logic [3:0] op);
    return {2'b11, op};
  endfunction

  typedef struct {
    logic [31:0] pc;
    logic        valid;
    logic [4:0]  dst;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t        sb_q [$];
  logic [31:0] prog [64];
  logic [31:0] mdl  [32];
  int          n_instr;
  int          checks;
  int          fails;
  bit          done;
  event        go;

  assign imem_data = prog[imem_addr[7:2]];

  function automatic logic [31:0] ref_op(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    case (op)
      OP_ADD: return a + b;
      OP_SUB: return a - b;
      OP_AND: return a & b;
      OP_OR:  return a | b;
      OP_XOR: return a ^ b;
      OP_SHL: return a << b[4:0];
      OP_SHR: return a >> b[4:0];
      OP_SRA: return 32'($signed(a) >>> b[4:0]);
      OP_EQ:  return {31'd0, a == b};
      OP_LT:  return {31'd0, $signed(a) < $signed(b)};
      OP_LE:  return {31'd0, $signed(a) <= $signed(b)};
      default: return 32'd0;
    endcase
  endfunction

  // driver: places an instruction (R3 layout) and queues its expected write-back
  task automatic put(input logic [5:0] opc, input int rc, input int ra,
                     input logic [15:0] low, input string req);
    exp_t        e;
    logic [31:0] a, b;
    logic        ok;
    int          rb;
    prog[n_instr] = {opc, 5'(rc), 5'(ra), low};
    rb = int'(low[15:11]);
    a  = mdl[ra];
    b  = opc[4] ? {{16{low[15]}}, low} : mdl[rb];
    ok = (opc[5:4] inside {2'b10, 2'b11}) && (opc[3:0] <= OP_LE);
    e.pc    = 32'(n_instr * 4);
    e.valid = ok && (rc != 31);
    e.dst   = 5'(rc);
    e.val   = ref_op(opc[3:0], a, b);
    e.req   = req;
    if (e.valid) mdl[rc] = e.val;
    sb_q.push_back(e);
    n_instr++;
  endtask

  function automatic logic [15:0] rbf(input int rb);
    return {5'(rb), 11'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected items and compares each retiring instruction
  initial begin
    exp_t e;
    @go;
    while (sb_q.size() > 0) begin
      #1;
      e = sb_q.pop_front();
      chk(imem_addr == e.pc, "R2", imem_addr, e.pc, "pc");
      chk(wb_valid == e.valid, e.req, 32'(wb_valid), 32'(e.valid), "wb_valid");
      if (e.valid) begin
        chk(wb_dst == e.dst, e.req, 32'(wb_dst), 32'(e.dst), "wb_dst");
        chk(wb_value == e.val, e.req, wb_value, e.val, "wb_value");
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    n_instr = 0;
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    for (int i = 0; i < 32; i++) mdl[i] = 32'd0;

    put(lit(OP_ADD), 1, 31, 16'h0005, "R3");
    put(lit(OP_ADD), 2, 31, 16'hFFFD, "R5");
    put(rr(OP_ADD), 3, 1, rbf(2), "R11");
    put(rr(OP_SUB), 4, 1, rbf(2), "R6");
    put(lit(OP_ADD), 5, 31, 16'h7FFF, "R5");
    put(lit(OP_ADD), 6, 31, 16'h8000, "R5");
    put(rr(OP_AND), 7, 5, rbf(6), "R6");
    put(rr(OP_OR), 8, 5, rbf(6), "R6");
    put(rr(OP_XOR), 9, 2, rbf(6), "R6");
    put(lit(OP_AND), 10, 6, 16'hF0F0, "R5");
    put(lit(OP_SHL), 11, 1, 16'h0004, "R7");
    put(rr(OP_SHR), 12, 6, rbf(1), "R7");
    put(rr(OP_SRA), 13, 6, rbf(1), "R7");
    put(lit(OP_SRA), 14, 2, 16'h0021, "R7");
    put(rr(OP_LT), 15, 2, rbf(1), "R8");
    put(rr(OP_LT), 16, 1, rbf(2), "R8");
    put(rr(OP_LE), 17, 1, rbf(1), "R8");
    put(rr(OP_EQ), 18, 1, rbf(2), "R8");
    put(lit(OP_EQ), 19, 1, 16'h0005, "R8");
    put(lit(OP_LE), 20, 2, 16'hFFFD, "R8");
    put(lit(OP_ADD), 31, 31, 16'h0063, "R10");
    put(rr(OP_ADD), 21, 31, rbf(31), "R10");
    put(6'h00, 1, 2, rbf(2), "R9");
    put(6'h2B, 1, 2, rbf(2), "R9");
    put(6'h3F, 1, 2, 16'h1234, "R9");
    put(lit(OP_ADD), 22, 1, 16'h0000, "R9");
    put(lit(OP_SUB), 23, 1, 16'hFFFF, "R5");
    put(lit(OP_OR), 24, 31, 16'h1234, "R4");
    put(lit(OP_XOR), 25, 24, 16'hFFFF, "R4");
    put(rr(OP_SHL), 26, 1, rbf(5), "R7");
    put(lit(OP_SHR), 27, 6, 16'h0010, "R7");
    put(rr(OP_ADD), 1, 1, rbf(1), "R12");
    put(rr(OP_ADD), 28, 1, rbf(31), "R11");
    put(lit(OP_LT), 29, 6, 16'h0000, "R8");

    // R1: reset holds the PC and suppresses the write of instruction 0
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(imem_addr == 32'd0, "R1", imem_addr, 32'd0, "reset pc");
      chk(wb_valid == 1'b0, "R1", 32'(wb_valid), 32'd0, "reset wb_valid");
    end
    @(negedge clk);
    rst_n = 1'b1;
    -> go;
  end

endmodule